// File: doc/BRIEF.md
# SRAM Read Output Stage with Selectable Latency and Deselect Depth

This block is the last stage of the read path in a synchronous SRAM behavioural model. Each clock edge it captures a command (read, write or no-operation) into its input register. It takes the array data that the array produces for the address captured at that same edge, and it produces the data bus value together with a bus-drive enable. An asynchronous active-low output enable gates the final drive.

Two static strap inputs shape the timing. The latency strap selects one of two read paths. In flow-through operation the array data passes straight to the bus in the cycle after capture, giving a 2-1-1-1 burst. In registered operation the data goes through an output register first, giving a 3-1-1-1 burst. The deselect strap sets how early the bus is released after a non-read command. Single-cycle deselect lets go of the bus in the cycle right after the command is captured. Dual-cycle deselect keeps driving for one more cycle and releases after the next edge. The straps are latched once, at the first clock edge after reset. A left-open strap is pulled high, which selects registered, single-cycle operation.

Top module: `sram_rd_out_stage`

## Requirements
- R1: With the latency strap `lat_sel_i` at 0 (flow-through), a read captured at edge k drives `dq_o` with the value of `arr_data_i` in the cycle that follows edge k, with `bus_en_o` high.
- R2: With `lat_sel_i` at 1 (registered), a read captured at edge k drives the array value of the cycle after edge k during the cycle after edge k+1.
- R3: Back-to-back reads produce one new data beat per clock, with no gap, after the first-beat latency.
- R4: With the deselect strap `dsel_sel_i` at 1 (single-cycle), the drive is off in every cycle that follows an edge which captured a non-read command. In registered mode this suppresses the beat of a read that is immediately followed by a non-read.
- R5: With `dsel_sel_i` at 0 (dual-cycle), the drive is off only after two consecutive edges capture non-read commands. A read always gets its beat, and in flow-through mode the bus keeps showing the last read beat for one extra cycle.
- R6: Command encoding on `cmd_i`: 2'b01 is read, 2'b10 is write, and 2'b00 and 2'b11 are no-operation/deselect. A write releases the bus with exactly the timing of a deselect.
- R7: While `oe_n_i` is high, `bus_en_o` is 0 and `dq_o` is 0 at once, without waiting for a clock edge. When it returns low, the pipeline state drives again in the same cycle.
- R8: During reset `bus_en_o` and `dq_o` are 0. With both straps held high, the block runs registered with single-cycle deselect.
- R9: The straps are latched at the first edge after reset release. Later changes of `lat_sel_i` or `dsel_sel_i` do not change the timing until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_sel_i | input | 1 | Latency strap: 0 flow-through, 1 registered |
| dsel_sel_i | input | 1 | Deselect strap: 1 single-cycle, 0 dual-cycle |
| cmd_i | input | 2 | Command captured each edge (R6 encoding) |
| arr_data_i | input | DATA_W | Array data for the address captured at the last edge |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dq_o | output | DATA_W | Read data bus value, 0 when not driven |
| bus_en_o | output | 1 | Bus drive enable |

## Verification
The bench compares every cycle of one mixed command stream with a cycle-accurate model, once for each of the four strap combinations. In registered single-cycle mode it looks for a read followed directly by a write or deselect. A design that pipelined the release as deep as a read would drive into the cycle meant for write data. In flow-through dual-cycle mode it checks the extra hold cycle, where a design that released too early would cut the bus one cycle short. It toggles the output enable between edges to catch gating that waits for the clock. It also flips the straps after the first edge, which would reveal straps that were being re-sampled while running.

// File: rtl/sro_pkg.sv
package sro_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } sro_cmd_e;
endpackage

// File: rtl/sro_cfg_latch.sv
module sro_cfg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lat_pin_i,
  input  logic dsel_pin_i,
  output logic cfg_reg_o,
  output logic cfg_dcd_o,
  output logic armed_o
);
  logic armed_q, armed_d;
  logic reg_q, reg_d;
  logic dcd_q, dcd_d;

  // straps load once, at the first edge after reset release
  always_comb begin
    armed_d = 1'b1;
    reg_d   = armed_q ? reg_q : lat_pin_i;
    dcd_d   = armed_q ? dcd_q : ~dsel_pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      reg_q   <= 1'b1;
      dcd_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      reg_q   <= reg_d;
      dcd_q   <= dcd_d;
    end
  end

  assign cfg_reg_o = reg_q;
  assign cfg_dcd_o = dcd_q;
  assign armed_o   = armed_q;

  // R9: configuration frozen once armed
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ($stable(reg_q) && $stable(dcd_q)));
endmodule

// File: rtl/sro_cmd_pipe.sv
module sro_cmd_pipe
  import sro_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd_i,
  output logic       s1_rd_o,
  output logic       s2_rd_o
);
  logic [STAGES-1:0] rd_q, rd_d;

  always_comb begin
    rd_d[0] = (cmd_i == CMD_READ);
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_comb rd_d[g] = rd_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign s1_rd_o = rd_q[0];
  assign s2_rd_o = rd_q[1];
endmodule

// File: rtl/sro_out_path.sv
module sro_out_path #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              s1_rd_i,
  input  logic              s2_rd_i,
  input  logic              cfg_reg_i,
  input  logic              cfg_dcd_i,
  output logic [DATA_W-1:0] dq_raw_o,
  output logic              drv_raw_o
);
  logic [DATA_W-1:0] out_q, out_d;
  logic              out_en;

  // output register loads only on a read beat
  always_comb begin
    out_en = s1_rd_i;
    out_d  = out_en ? arr_data_i : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  always_comb begin
    if (cfg_reg_i) begin
      dq_raw_o  = out_q;
      drv_raw_o = s2_rd_i & (cfg_dcd_i | s1_rd_i);
    end else begin
      dq_raw_o  = s1_rd_i ? arr_data_i : out_q;
      drv_raw_o = s1_rd_i | (cfg_dcd_i & s2_rd_i);
    end
  end
endmodule

// File: rtl/sram_rd_out_stage.sv
module sram_rd_out_stage
  import sro_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_sel_i,
  input  logic              dsel_sel_i,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              bus_en_o
);
  logic              cfg_reg, cfg_dcd, armed;
  logic              s1_rd, s2_rd;
  logic [DATA_W-1:0] dq_raw;
  logic              drv_raw;

  sro_cfg_latch i_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_pin_i  (lat_sel_i),
    .dsel_pin_i (dsel_sel_i),
    .cfg_reg_o  (cfg_reg),
    .cfg_dcd_o  (cfg_dcd),
    .armed_o    (armed)
  );

  sro_cmd_pipe #(.STAGES(2)) i_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_i   (cmd_i),
    .s1_rd_o (s1_rd),
    .s2_rd_o (s2_rd)
  );

  sro_out_path #(.DATA_W(DATA_W)) i_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_data_i (arr_data_i),
    .s1_rd_i    (s1_rd),
    .s2_rd_i    (s2_rd),
    .cfg_reg_i  (cfg_reg),
    .cfg_dcd_i  (cfg_dcd),
    .dq_raw_o   (dq_raw),
    .drv_raw_o  (drv_raw)
  );

  // asynchronous output-enable gate
  always_comb begin
    bus_en_o = drv_raw & ~oe_n_i;
    dq_o     = bus_en_o ? dq_raw : '0;
  end

  // R4: single-cycle deselect releases right after capture
  p_scd_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cfg_dcd && $past(cmd_i) != CMD_READ) |-> !drv_raw);

  // R5: dual-cycle deselect needs two non-read captures
  p_dcd_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfg_dcd && $past(cmd_i) != CMD_READ && !$past(s1_rd)) |-> !drv_raw);

  // R5: a read one stage back still drives under dual-cycle deselect
  p_dcd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfg_dcd && $past(s1_rd)) |-> drv_raw);

  // R1: flow-through beat equals current array data
  p_ft_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cfg_reg && $past(cmd_i) == CMD_READ) |-> (drv_raw && dq_raw == arr_data_i));

  // R2: registered beat equals array data of the previous cycle
  p_reg_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfg_reg && drv_raw) |-> (dq_raw == $past(arr_data_i)));
endmodule

// File: tb/test_sram_rd_out_stage.sv
`timescale 1ns/1ps
module test_sram_rd_out_stage;
  localparam int DW = 36;
  localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, RSV = 2'b11;

  logic          clk;
  logic          rst_n;
  logic          lat_sel, dsel_sel;
  logic [1:0]    cmd;
  logic [DW-1:0] arr;
  logic          oe_n;
  logic [DW-1:0] dq;
  logic          bus_en;

  int n_chk, n_fail, pat_n;
  // reference state
  logic          m_ft, m_dcd;
  logic [1:0]    c0, c1;
  logic [DW-1:0] ac, ap;
  string         xtag;

  sram_rd_out_stage #(.DATA_W(DW)) i_sram_rd_out_stage (
    .clk(clk), .rst_n(rst_n), .lat_sel_i(lat_sel), .dsel_sel_i(dsel_sel),
    .cmd_i(cmd), .arr_data_i(arr), .oe_n_i(oe_n), .dq_o(dq), .bus_en_o(bus_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int n);
    return DW'(n * 40503 + 17) ^ {n[3:0], 32'h0};
  endfunction

  task automatic do_reset(input logic ft, input logic dcd);
    rst_n = 1'b0; lat_sel = ~ft; dsel_sel = ~dcd; cmd = NOP; oe_n = 1'b0;
    arr = '0;
    repeat (2) @(posedge clk);
    #2;
    chk("R8 reset bus_en", 64'(bus_en), 64'd0);
    chk("R8 reset dq", 64'(dq), 64'd0);
    @(negedge clk) rst_n = 1'b1;
    m_ft = ft; m_dcd = dcd; c0 = NOP; c1 = NOP; ac = '0; ap = '0;
  endtask

  // one cycle: command captured at next edge, array data follows, then compare
  task automatic step(input logic [1:0] c);
    logic rd0, rd1, en;
    logic [DW-1:0] ed;
    string dtag, etag;
    @(negedge clk) cmd = c;
    @(posedge clk);
    #1;
    c1 = c0; c0 = c; ap = ac; ac = pat(pat_n); pat_n++;
    arr = ac;
    #2;
    rd0 = (c0 == RD); rd1 = (c1 == RD);
    if (m_ft) en = rd0 | (m_dcd & rd1);
    else      en = rd1 & (m_dcd | rd0);
    en = en & ~oe_n;
    ed = en ? (m_ft ? (rd0 ? ac : ap) : ap) : '0;
    dtag = m_ft ? "R1 data" : "R2 data";
    etag = m_dcd ? "R5 drive" : "R4 drive";
    if (c0 == WR || c1 == WR) etag = {etag, " R6"};
    chk({etag, " ", xtag}, 64'(bus_en), 64'(en));
    chk({dtag, " ", xtag}, 64'(dq), 64'(ed));
  endtask

  task automatic run_seq();
    logic [1:0] s [16] = '{RD, RD, RD, RD, NOP, RD, NOP, NOP, RD, WR, RD, RD, WR, RSV, RD, NOP};
    foreach (s[i]) step(s[i]);
    step(NOP); step(NOP);
  endtask

  task automatic t_modes();
    xtag = "";
    for (int m = 0; m < 4; m++) begin
      do_reset(m[0], m[1]);
      run_seq();
    end
  endtask

  task automatic t_burst_r3();
    logic [DW-1:0] b [4];
    xtag = "R3";
    do_reset(1'b0, 1'b0);
    step(RD); step(RD); step(RD); step(RD);
    step(NOP);
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(RD);
      b[i] = dq;
      chk("R3 flow-through beat each clock", 64'(bus_en), 64'd1);
    end
    chk("R3 beats distinct", 64'(b[1] != b[2]), 64'd1);
    step(NOP); step(NOP);
  endtask

  task automatic t_write_r6();
    xtag = "R6";
    do_reset(1'b0, 1'b0);
    step(RD); step(WR);
    chk("R6 read then write freed in single-cycle", 64'(bus_en), 64'd0);
    step(RD); step(RD); step(WR); step(NOP);
    do_reset(1'b1, 1'b1);
    step(RD); step(WR);
    chk("R6 write holds one cycle in dual-cycle", 64'(bus_en), 64'd1);
    step(WR);
    chk("R6 released after second edge", 64'(bus_en), 64'd0);
  endtask

  task automatic t_oe_r7();
    xtag = "R7";
    do_reset(1'b0, 1'b1);
    step(RD); step(RD); step(RD);
    oe_n = 1'b1; #1;
    chk("R7 oe high bus_en", 64'(bus_en), 64'd0);
    chk("R7 oe high dq", 64'(dq), 64'd0);
    oe_n = 1'b0; #1;
    chk("R7 oe low bus_en", 64'(bus_en), 64'd1);
    chk("R7 oe low dq", 64'(dq), 64'(ap));
    step(NOP); step(NOP);
  endtask

  task automatic t_default_r8();
    xtag = "R8";
    do_reset(1'b0, 1'b0);
    lat_sel = 1'b1; dsel_sel = 1'b1;
    step(RD);
    chk("R8 default no flow-through beat", 64'(bus_en), 64'd0);
    step(RD);
    chk("R8 default registered beat", 64'(bus_en), 64'd1);
    step(NOP);
    chk("R8 default single-cycle release", 64'(bus_en), 64'd0);
  endtask

  task automatic t_cfg_r9();
    xtag = "R9";
    do_reset(1'b1, 1'b0);
    step(NOP);
    lat_sel = 1'b1; dsel_sel = 1'b0;
    step(RD);
    chk("R9 still flow-through", 64'(bus_en), 64'd1);
    step(NOP);
    chk("R9 still single-cycle", 64'(bus_en), 64'd0);
    step(RD); step(RD); step(NOP);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; pat_n = 1; xtag = "";
    rst_n = 1'b0; lat_sel = 1'b1; dsel_sel = 1'b1; cmd = NOP; arr = '0; oe_n = 1'b0;
    t_default_r8();
    t_modes();
    t_burst_r3();
    t_write_r6();
    t_oe_r7();
    t_cfg_r9();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule